// File: doc/BRIEF.md
# Shared Level Interrupt Aggregator

This block folds the level-sensitive requests of several endpoint slots onto a small number of shared interrupt lines. Every slot offers four request pins. The block remembers the level it last accepted on each pin, so only a genuine transition counts as an event. On each event it steers the pin to a shared line through a rotation that depends on the slot and the pin. It then raises or lowers a counter of active sources that belongs to that line.

A line output is high while its counter holds a non-zero value. Seen from outside, each line behaves as the OR of every source routed to it. Internally, the counter means that a source which stays high is counted once, and the line falls only when the last active source on it drops. The input is one flat bus of pin levels, slot by slot. The output is one bus with a bit per shared line. The reset input is asynchronous and active low, and it is expected to be released synchronously to the clock.

Top module: `irq_line_merger`

## Requirements
- R1: While reset is low, every line output is low and all stored pin states and counters are cleared. After release, a pin that is already high counts as a new assertion at the first rising edge.
- R2: Each slot has four pins. Pin p of slot s is input bit s*4+p, with p from 0 to 3.
- R3: Pin p of slot s drives line (p + s) mod NUM_LINES (default NUM_LINES = 4).
- R4: A line is high exactly while at least one stored-high source is routed to it. It stays high until the last such source returns low.
- R5: A pin level equal to the stored level causes no action. A pin held high over many cycles is counted only once.
- R6: All pin changes in one cycle are applied in that cycle. A rise and a fall on the same line in the same cycle leave that line's count unchanged.
- R7: A change at the pins shows at the line outputs after exactly one rising clock edge, not before.
- R8: Counters hold 4*NUM_SLOTS without overflow. With every pin high, all lines are high, and they return low when all pins drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | NUM_SLOTS*4 | Request levels, slot s pin p at bit s*4+p |
| line_o | output | NUM_LINES | Shared interrupt line outputs |

## Verification
Two things can land in the same cycle: an assertion and a deassertion from different sources that route to one line, and several sources of one line changing together. Both are provoked by moving from one pin pattern to another in a single step. For example, slot 0 pin 0 goes low while slot 2 pin 2 goes high, and both route to line 0. The bench then judges the line level one edge later against a value worked out by hand. A correct count keeps the line high through the swap and drops it only when the final source falls.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  // Request pins presented by every endpoint slot.
  localparam int PINS_PER_SLOT = 4;

  // Shared line reached by a given slot and pin.
  function automatic int route_line(input int slot, input int pin, input int nlines);
    return (pin + slot) % nlines;
  endfunction
endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pin_lvl_i,
  output logic [NUM_SRC-1:0] seen_o,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] fall_o
);
  logic [NUM_SRC-1:0] seen_q;
  logic [NUM_SRC-1:0] seen_d;
  logic [NUM_SRC-1:0] chg;
  logic               upd_en;

  // Next state: only a difference from the stored level is an event.
  always_comb begin
    chg    = pin_lvl_i ^ seen_q;
    upd_en = |chg;
    seen_d = pin_lvl_i;
    rise_o = chg & pin_lvl_i;
    fall_o = chg & seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (upd_en) begin
      seen_q <= seen_d;
    end
  end

  assign seen_o = seen_q;
endmodule

// File: rtl/irq_route_sum.sv
module irq_route_sum
  import irq_merge_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_LINES = 4,
  parameter int STEP_W    = 5
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] rise_i,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] fall_i,
  output logic [STEP_W-1:0]                  up_o [NUM_LINES],
  output logic [STEP_W-1:0]                  dn_o [NUM_LINES]
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_comb begin
      up_o[l] = '0;
      dn_o[l] = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < PINS_PER_SLOT; p++) begin
          if (route_line(s, p, NUM_LINES) == l) begin
            up_o[l] = up_o[l] + STEP_W'(rise_i[s*PINS_PER_SLOT+p]);
            dn_o[l] = dn_o[l] + STEP_W'(fall_i[s*PINS_PER_SLOT+p]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int CNT_W   = 5,
  parameter int MAX_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] up_i,
  input  logic [CNT_W-1:0] dn_i,
  output logic             line_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (up_i != dn_i);
    cnt_d  = cnt_q + up_i - dn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign line_o = |cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_CNT)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dn_i <= cnt_q); // R4
endmodule

// File: rtl/irq_line_merger.sv
module irq_line_merger
  import irq_merge_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_LINES = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_lvl_i,
  output logic [NUM_LINES-1:0]               line_o
);
  localparam int NUM_SRC = NUM_SLOTS * PINS_PER_SLOT;
  localparam int CNT_W   = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] seen;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] fall;
  logic [CNT_W-1:0]   up   [NUM_LINES];
  logic [CNT_W-1:0]   dn   [NUM_LINES];

  irq_pin_tracker #(.NUM_SRC(NUM_SRC)) i_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl_i (pin_lvl_i),
    .seen_o    (seen),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  irq_route_sum #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_LINES (NUM_LINES),
    .STEP_W    (CNT_W)
  ) i_route (
    .rise_i (rise),
    .fall_i (fall),
    .up_o   (up),
    .dn_o   (dn)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
    irq_line_counter #(.CNT_W(CNT_W), .MAX_CNT(NUM_SRC)) i_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .up_i   (up[l]),
      .dn_i   (dn[l]),
      .line_o (line_o[l])
    );
  end

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == '0) |-> (line_o == '0)); // R4

  AST_QUIET_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise == '0) && (fall == '0)) |=> $stable(line_o)); // R5
endmodule

// File: tb/test_irq_line_merger.sv
module test_irq_line_merger;
  logic        clk;
  logic        rst_n;
  logic [15:0] pins;
  logic [3:0]  line;
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  irq_line_merger #(.NUM_SLOTS(4), .NUM_LINES(4)) i_irq_line_merger (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl_i (pins),
    .line_o    (line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {pin levels, expected lines}; pin s*4+p goes to line (s+p)%4.
  localparam logic [19:0] VEC [12] = '{
    {16'h0001, 4'h1},  // R3 s0p0 -> line0
    {16'h0003, 4'h3},  // R3 s0p1 -> line1
    {16'h0010, 4'h2},  // R6 fall on 0 and 1, rise on 1 together
    {16'h0110, 4'h6},  // R3 s2p0 -> line2
    {16'h8000, 4'h4},  // R2 s3p3 bit15 -> line2
    {16'h8421, 4'h5},  // R6 several rises at once
    {16'h8020, 4'h4},  // R4 both line0 sources drop
    {16'h1248, 4'h8},  // R3 four sources on line3
    {16'h1240, 4'h8},  // R4 line3 still held by others
    {16'h0000, 4'h0},  // R4 last sources leave
    {16'hFFFF, 4'hF},  // R8 every pin high
    {16'h0000, 4'h0}   // R8 all drop
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: line_o=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] p);
    @(negedge clk);
    pins = p;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    pins  = 16'h0001;
    repeat (3) @(negedge clk);
    chk("R1", line, 4'h0);               // reset holds lines low
    rst_n = 1'b1;
    #1 chk("R7", line, 4'h0);            // nothing before an edge
    @(negedge clk);
    chk("R1", line, 4'h1);               // high pin counted after release
    step(16'h0000);
    chk("R1", line, 4'h0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][19:4]);
      chk($sformatf("R3/R4 vec%0d", i), line, VEC[i][3:0]);
    end

    // R5: holding a level does not count again
    step(16'h0001);
    repeat (4) @(negedge clk);
    chk("R5", line, 4'h1);
    step(16'h0011);
    chk("R5", line, 4'h3);
    step(16'h0010);
    chk("R5", line, 4'h2);               // line0 drops: counted once
    step(16'h0000);
    chk("R5", line, 4'h0);

    // R6: swap between two sources of line0 in one cycle
    step(16'h0001);
    step(16'h0400);
    chk("R6", line, 4'h1);
    step(16'h0000);
    chk("R6", line, 4'h0);

    // R7: change visible only after a rising edge
    @(negedge clk);
    pins = 16'h0002;
    #1 chk("R7", line, 4'h0);
    @(negedge clk);
    chk("R7", line, 4'h2);

    // R1: reset mid-run clears counts
    pins = 16'h0000;
    @(negedge clk);
    pins = 16'hFFFF;
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1", line, 4'h0);
    pins = 16'h0000;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", line, 4'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: line_o=%h expected=finish", line);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule